// File: doc/BRIEF.md
# Three-Pin GPIO Port Register Block

A register-mapped general-purpose I/O port that controls three pins. Two 8-bit registers sit on a simple bus with an address, a write strobe, a read strobe and 8-bit data. The direction register picks, for each pin, whether it drives (1) or listens (0). The output data register holds the value each pin drives. Only bits 2..0 of each register are implemented. The upper five bits are reserved and read as ones.

A read of the port data address returns a per-bit mix. Each pin set as an output returns its latched data bit. Each pin set as an input returns the pad level after a two-flop synchronizer. The direction register cannot be read back, so a read of its address gives no defined value. Hardware standby returns both registers to their reset contents. Software standby freezes them.

Top module: `gpio3_port`

## Requirements
- R1: After reset (rst_ni low, asynchronous), the direction and output data bits are all 0. pin_oe_o reads 3'b000 and pin_o reads 3'b000. With all pads low, a read of the data address (address 1) returns 8'hF8.
- R2: A write to the direction address (address 0) with wr_i high updates pin_oe_o at the next rising edge. pin_oe_o equals wdata_i[2:0], where 1 drives the pin and 0 releases it. wdata_i[7:3] has no effect.
- R3: A write to the data address (address 1) updates pin_o to wdata_i[2:0] at the next rising edge. A read of the data address always returns ones in bits 7..3.
- R4: A read of the data address returns, for each bit i in 0..2, the stored output bit when direction bit i is 1 and the synchronized pad_i[i] when it is 0.
- R5: A change on pad_i appears in the read data after exactly two rising clock edges, and not after one.
- R6: While hw_stby_i is high, both registers return to their reset contents at each rising edge. This takes priority over a write in the same cycle.
- R7: While sw_stby_i is high, both registers keep their contents and bus writes are ignored.
- R8: With rd_i high, any address other than 0 or 1 reads 8'hFF. With rd_i low, rdata_o is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_stby_i | input | 1 | Hardware standby, resets registers |
| sw_stby_i | input | 1 | Software standby, holds registers |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pad_i | input | 3 | Pad input levels |
| pin_o | output | 3 | Pin output values |
| pin_oe_o | output | 3 | Pin output enables |

## Verification
Register writes show on pin_o and pin_oe_o one rising edge after the strobe. Reads are combinational in the cycle the strobe and address are presented. Pad changes reach the read data only after the second edge. The driver applies all stimulus at falling edges. It queues each expected value only once the edges that result needs have passed. The monitor compares one time unit after each falling edge. For the pad path, the bench checks once after one edge, expecting the old value, and again after the second edge, expecting the new one.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
  localparam int DW     = 8;
  localparam int PINS   = 3;
  localparam int AW     = 2;
  localparam logic [AW-1:0] ADDR_DIR  = 2'd0;
  localparam logic [AW-1:0] ADDR_DATA = 2'd1;
  localparam logic [DW-1:0] RSVD_ONES = {DW{1'b1}};
endpackage

// File: rtl/gpio3_sync.sv
module gpio3_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= d_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign q_o = s2_q;

  // cycles since reset, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R5
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio3_regs.sv
module gpio3_regs
  import gpio3_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hw_stby_i,
  input  logic            sw_stby_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [PINS-1:0] wbits_i,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] dout_o
);
  logic [PINS-1:0] dir_q, dout_q;
  logic wr_ok;

  assign wr_ok = wr_i && !sw_stby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else if (hw_stby_i) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == ADDR_DIR)  dir_q  <= wbits_i;
      if (addr_i == ADDR_DATA) dout_q <= wbits_i;
    end
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;

  // R6
  hw_stby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (dir_q == '0 && dout_q == '0));

  // R7
  sw_stby_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !hw_stby_i) |=> ($stable(dir_q) && $stable(dout_q)));

  // R3
  data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sw_stby_i && !hw_stby_i && addr_i == ADDR_DATA)
      |=> (dout_q == $past(wbits_i)));

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sw_stby_i && !hw_stby_i && addr_i == ADDR_DIR)
      |=> (dir_q == $past(wbits_i)));
endmodule

// File: rtl/gpio3_rdmux.sv
module gpio3_rdmux
  import gpio3_pkg::*;
(
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [PINS-1:0] dir_i,
  input  logic [PINS-1:0] dout_i,
  input  logic [PINS-1:0] pad_sync_i,
  output logic [DW-1:0]   rdata_o
);
  logic [PINS-1:0] mix;

  for (genvar i = 0; i < PINS; i++) begin : g_mix
    assign mix[i] = dir_i[i] ? dout_i[i] : pad_sync_i[i];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      // direction address has no defined read value; all ones is returned
      if (addr_i == ADDR_DATA) rdata_o = {RSVD_ONES[DW-1:PINS], mix};
      else                     rdata_o = RSVD_ONES;
    end
  end
endmodule

// File: rtl/gpio3_port.sv
module gpio3_port
  import gpio3_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hw_stby_i,
  input  logic            sw_stby_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [PINS-1:0] pad_i,
  output logic [PINS-1:0] pin_o,
  output logic [PINS-1:0] pin_oe_o
);
  logic [PINS-1:0] dir, dout, pad_sync;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DW-1:PINS];

  gpio3_sync #(.W(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  gpio3_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wbits_i   (wdata_i[PINS-1:0]),
    .dir_o     (dir),
    .dout_o    (dout)
  );

  gpio3_rdmux u_rdmux (
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .dir_i      (dir),
    .dout_i     (dout),
    .pad_sync_i (pad_sync),
    .rdata_o    (rdata_o)
  );

  assign pin_o    = dout;
  assign pin_oe_o = dir;

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != ADDR_DIR && addr_i != ADDR_DATA) |-> (rdata_o == 8'hFF));

  // R3
  rsvd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_DATA) |-> (rdata_o[DW-1:PINS] == '1));
endmodule

// File: tb/tb_gpio3_port.sv
`timescale 1ns/1ps
module tb_gpio3_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0, sw_stby = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] pad = '0, pin, pin_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [7:0] exp; string req; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  gpio3_port dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_stby_i(hw_stby), .sw_stby_i(sw_stby),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .pad_i(pad), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  // kind: 0 rdata, 1 pin_o, 2 pin_oe_o
  task automatic expect_val(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {5'b0, pin};
        default: act = {5'b0, pin_oe};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a);
    addr = a; rd = 1'b1; wr = 1'b0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(3);
    bus_rd(2'd1);
    expect_val(2, 8'h00, "R1"); expect_val(1, 8'h00, "R1"); expect_val(0, 8'hF8, "R1");
    step(1);
    // pad latency
    pad = 3'b101;
    step(1);
    expect_val(0, 8'hF8, "R5 one edge");
    step(1);
    expect_val(0, 8'hFD, "R5 two edges");
    step(1);
    // direction write, upper bits ignored
    bus_wr(2'd0, 8'hFF);
    expect_val(2, 8'h07, "R2");
    step(1);
    bus_wr(2'd1, 8'h02);
    expect_val(1, 8'h02, "R3");
    bus_rd(2'd1);
    expect_val(0, 8'hFA, "R3");
    step(1);
    // mixed read
    bus_wr(2'd0, 8'hF5);
    bus_wr(2'd1, 8'h01);
    pad = 3'b110;
    step(2);
    bus_rd(2'd1);
    expect_val(0, 8'hFB, "R4");
    step(1);
    // software standby
    sw_stby = 1'b1;
    bus_wr(2'd1, 8'h06);
    bus_wr(2'd0, 8'h00);
    expect_val(1, 8'h01, "R7"); expect_val(2, 8'h05, "R7");
    step(1);
    sw_stby = 1'b0;
    // hardware standby vs write
    pad = 3'b000;
    hw_stby = 1'b1;
    bus_wr(2'd0, 8'h07);
    expect_val(2, 8'h00, "R6"); expect_val(1, 8'h00, "R6");
    hw_stby = 1'b0;
    step(2);
    bus_rd(2'd1);
    expect_val(0, 8'hF8, "R6");
    step(1);
    bus_rd(2'd2);
    expect_val(0, 8'hFF, "R8");
    step(1);
    bus_rd(2'd3);
    expect_val(0, 8'hFF, "R8");
    step(1);
    rd = 1'b0; addr = 2'd1;
    expect_val(0, 8'h00, "R8");
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule